// File: doc/BRIEF.md
# Dual-Insert Top-N Sorted Buffer

This block keeps a ranked list of the largest correlation metrics seen during one metric pass. Two cross-correlators deliver their results side by side, so each accepted cycle carries two metric/index pairs, and both are merged into the ranked list in the same cycle. The list always stays in descending order: slot 0 holds the largest metric and the last slot holds the smallest one that is still kept.

A pass begins with a start pulse, which empties the list to metric zero. Pairs then arrive with a valid strobe, and the final pair of the pass is marked with last. One cycle after that final pair has been merged, the done flag rises. The list then holds still and can be read by a downstream candidate store, until the next start pulse.

Top module: `topn_dual_sorter`

## Requirements
- R1: After reset every slot holds metric 0 and index 0, and done_o is low.
- R2: A start_i pulse sets every slot to metric 0 and index 0 and drives done_o low on the next cycle; a pair presented with start_i in the same cycle is not inserted.
- R3: On each cycle with valid_i high, start_i low and done_o low, both input pairs are merged into the list, and the new contents appear on the outputs after that clock edge.
- R4: The slots are in non-increasing metric order; slot k is bits [k*16 +: 16] of rank_metric_o and bits [k*4 +: 4] of rank_idx_o, and slot 0 is the largest.
- R5: Only the 8 largest metrics are kept; a value no larger than the smallest kept metric is discarded, and a larger one pushes the smallest kept entry out.
- R6: Equal metrics keep arrival order: an entry already in the list ranks above a newly arriving equal one, and of the two pairs in one cycle, pair 0 ranks above pair 1.
- R7: done_o rises on the cycle after an accepted insertion with last_i high, and stays high until the next start_i.
- R8: While done_o is high, valid pairs are ignored and the list does not change.
- R9: Cycles with valid_i low leave the list and done_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clears the list for a new pass |
| valid_i | input | 1 | Both input pairs are valid this cycle |
| last_i | input | 1 | The current pair is the last of the pass |
| metric0_i | input | 16 | Metric from correlator 0 |
| idx0_i | input | 4 | Pattern index for metric 0 |
| metric1_i | input | 16 | Metric from correlator 1 |
| idx1_i | input | 4 | Pattern index for metric 1 |
| rank_metric_o | output | 128 | Ranked metrics, slot 0 in the low bits |
| rank_idx_o | output | 32 | Ranked pattern indices, slot 0 in the low bits |
| done_o | output | 1 | Pass complete, list frozen |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it: a merged pair, the cleared list after start, and the rise of done all come from a single register stage. The bench drives inputs on the falling edge, lets one rising edge pass, and reads the outputs on the next falling edge, against a ranked model that it updates at the moment of driving. Held-state cases (idle cycles and pairs after done) are checked after the same one-edge delay, so that a wrongly taken update would already be visible.

// File: rtl/sort_pkg.sv
package sort_pkg;
    parameter int METRIC_W  = 16;
    parameter int IDX_W     = 4;
    parameter int DEPTH_DEF = 8;

    typedef struct packed {
        logic [METRIC_W-1:0] metric;
        logic [IDX_W-1:0]    idx;
    } entry_t;

    localparam entry_t ENTRY_EMPTY = '{metric: '0, idx: '0};
endpackage

// File: rtl/topn_insert_stage.sv
module topn_insert_stage
    import sort_pkg::*;
#(
    parameter int DEPTH = DEPTH_DEF
) (
    input  entry_t [DEPTH-1:0] list_i,
    input  entry_t             new_i,
    input  logic               en_i,
    output entry_t [DEPTH-1:0] list_o
);
    // above[k]: the new entry ranks strictly above slot k (ties stay below)
    logic [DEPTH-1:0] above;

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        assign above[k] = en_i && (new_i.metric > list_i[k].metric);
        if (k == 0) begin : g_top
            assign list_o[k] = above[k] ? new_i : list_i[k];
        end else begin : g_rest
            assign list_o[k] = !above[k]    ? list_i[k]   :
                               above[k-1]   ? list_i[k-1] : new_i;
        end
    end
endmodule

// File: rtl/topn_dual_sorter.sv
module topn_dual_sorter
    import sort_pkg::*;
#(
    parameter int DEPTH = DEPTH_DEF,
    parameter int MW    = METRIC_W,
    parameter int IW    = IDX_W
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic                valid_i,
    input  logic                last_i,
    input  logic [MW-1:0]       metric0_i,
    input  logic [IW-1:0]       idx0_i,
    input  logic [MW-1:0]       metric1_i,
    input  logic [IW-1:0]       idx1_i,
    output logic [DEPTH*MW-1:0] rank_metric_o,
    output logic [DEPTH*IW-1:0] rank_idx_o,
    output logic                done_o
);
    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
        logic               done;
    } state_t;

    state_t state_d, state_q;
    entry_t [DEPTH-1:0] after0, after1;
    entry_t in0, in1;
    logic   accept;

    assign in0    = '{metric: metric0_i, idx: idx0_i};
    assign in1    = '{metric: metric1_i, idx: idx1_i};
    assign accept = valid_i && !start_i && !state_q.done;

    // Pair 0 is merged first so that it counts as the earlier arrival.
    topn_insert_stage #(.DEPTH(DEPTH)) u_ins0 (
        .list_i (state_q.ent),
        .new_i  (in0),
        .en_i   (accept),
        .list_o (after0)
    );

    topn_insert_stage #(.DEPTH(DEPTH)) u_ins1 (
        .list_i (after0),
        .new_i  (in1),
        .en_i   (accept),
        .list_o (after1)
    );

    always_comb begin
        state_d = state_q;
        if (start_i) begin
            for (int k = 0; k < DEPTH; k++) state_d.ent[k] = ENTRY_EMPTY;
            state_d.done = 1'b0;
        end else if (accept) begin
            state_d.ent  = after1;
            state_d.done = last_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int k = 0; k < DEPTH; k++) state_q.ent[k] <= ENTRY_EMPTY;
            state_q.done <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_out
        assign rank_metric_o[k*MW +: MW] = state_q.ent[k].metric;
        assign rank_idx_o[k*IW +: IW]    = state_q.ent[k].idx;
    end
    assign done_o = state_q.done;
endmodule

// File: rtl/topn_dual_sorter_chk.sv
module topn_dual_sorter_chk #(
    parameter int DEPTH = 8,
    parameter int MW    = 16,
    parameter int IW    = 4
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                start_i,
    input logic                valid_i,
    input logic                last_i,
    input logic [DEPTH*MW-1:0] rank_metric_o,
    input logic [DEPTH*IW-1:0] rank_idx_o,
    input logic                done_o
);
    for (genvar k = 1; k < DEPTH; k++) begin : g_ord
        AST_RANK_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
            rank_metric_o[(k-1)*MW +: MW] >= rank_metric_o[k*MW +: MW]); // R4
    end

    AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (rank_metric_o == '0) && (rank_idx_o == '0) && !done_o); // R2

    AST_DONE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && last_i && !start_i && !done_o) |=> done_o); // R7

    AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !start_i) |=> done_o); // R7

    AST_FROZEN_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !start_i) |=> $stable(rank_metric_o) && $stable(rank_idx_o)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!valid_i && !start_i) |=> $stable(rank_metric_o) && $stable(rank_idx_o)
                                   && $stable(done_o)); // R9

    AST_MAX_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && !start_i) |=> rank_metric_o[MW-1:0] >= $past(rank_metric_o[MW-1:0])); // R5
endmodule

bind topn_dual_sorter topn_dual_sorter_chk #(.DEPTH(DEPTH), .MW(MW), .IW(IW)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .valid_i       (valid_i),
    .last_i        (last_i),
    .rank_metric_o (rank_metric_o),
    .rank_idx_o    (rank_idx_o),
    .done_o        (done_o)
);

// File: tb/topn_dual_sorter_tb_top.sv
module topn_dual_sorter_tb_top;
    localparam int DEPTH = 8;
    localparam int MW    = 16;
    localparam int IW    = 4;

    logic                clk_i = 1'b0;
    logic                rst_ni = 1'b0;
    logic                start_i = 1'b0;
    logic                valid_i = 1'b0;
    logic                last_i = 1'b0;
    logic [MW-1:0]       metric0_i = '0;
    logic [IW-1:0]       idx0_i = '0;
    logic [MW-1:0]       metric1_i = '0;
    logic [IW-1:0]       idx1_i = '0;
    logic [DEPTH*MW-1:0] rank_metric_o;
    logic [DEPTH*IW-1:0] rank_idx_o;
    logic                done_o;

    int errs   = 0;
    int checks = 0;

    logic [MW-1:0] mm [DEPTH];
    logic [IW-1:0] mi [DEPTH];
    logic          mdone;

    always #4 clk_i = ~clk_i;

    topn_dual_sorter #(.DEPTH(DEPTH), .MW(MW), .IW(IW)) dut_i (
        .clk_i, .rst_ni, .start_i, .valid_i, .last_i,
        .metric0_i, .idx0_i, .metric1_i, .idx1_i,
        .rank_metric_o, .rank_idx_o, .done_o
    );

    task automatic model_clear();
        for (int k = 0; k < DEPTH; k++) begin mm[k] = '0; mi[k] = '0; end
        mdone = 1'b0;
    endtask

    // Ranked model: a new value sits below all equal values already held.
    task automatic model_put(input logic [MW-1:0] m, input logic [IW-1:0] i);
        int p;
        p = DEPTH;
        for (int k = DEPTH - 1; k >= 0; k--) if (m > mm[k]) p = k;
        if (p < DEPTH) begin
            for (int k = DEPTH - 1; k > p; k--) begin mm[k] = mm[k-1]; mi[k] = mi[k-1]; end
            mm[p] = m; mi[p] = i;
        end
    endtask

    task automatic check_all(input string tag);
        logic bad;
        bad = 1'b0;
        checks++;
        for (int k = 0; k < DEPTH; k++) begin
            if (!bad && (rank_metric_o[k*MW +: MW] !== mm[k] || rank_idx_o[k*IW +: IW] !== mi[k])) begin
                bad = 1'b1;
                $display("FAIL %s slot %0d: actual %0d/%0d expected %0d/%0d", tag, k,
                         rank_metric_o[k*MW +: MW], rank_idx_o[k*IW +: IW], mm[k], mi[k]);
            end
        end
        if (!bad && done_o !== mdone) begin
            bad = 1'b1;
            $display("FAIL %s done: actual %0b expected %0b", tag, done_o, mdone);
        end
        if (bad) errs++;
    endtask

    // Drive at negedge, one rising edge passes, results read at next negedge.
    task automatic cyc(input logic st, input logic v, input logic l,
                       input logic [MW-1:0] a, input logic [IW-1:0] ai,
                       input logic [MW-1:0] b, input logic [IW-1:0] bi);
        start_i = st; valid_i = v; last_i = l;
        metric0_i = a; idx0_i = ai; metric1_i = b; idx1_i = bi;
        if (st) model_clear();
        else if (v && !mdone) begin
            model_put(a, ai);
            model_put(b, bi);
            mdone = l;
        end
        @(negedge clk_i);
        start_i = 1'b0; valid_i = 1'b0; last_i = 1'b0;
    endtask

    task automatic t_reset();
        model_clear();
        check_all("R1");
    endtask

    task automatic t_basic();
        cyc(1, 0, 0, 0, 0, 0, 0);
        check_all("R2");
        cyc(0, 1, 0, 300, 1, 500, 2);
        check_all("R3");
        cyc(0, 1, 0, 400, 3, 100, 4);
        check_all("R4");
        cyc(0, 1, 0, 600, 5, 50, 6);
        check_all("R3");
    endtask

    task automatic t_ties();
        cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 100, 1, 7, 9);
        cyc(0, 1, 0, 100, 2, 100, 3);
        check_all("R6");
        cyc(0, 1, 0, 0, 5, 0, 6);
        check_all("R6");
    endtask

    task automatic t_burst(input int n, input int span);
        cyc(1, 0, 0, 0, 0, 0, 0);
        for (int j = 0; j < n; j++) begin
            cyc(0, 1, (j == n - 1), MW'($urandom_range(span)), IW'($urandom),
                MW'($urandom_range(span)), IW'($urandom));
            if (j == n - 2) check_all("R7");
        end
        check_all("R5");
    endtask

    task automatic t_after_done();
        cyc(0, 1, 0, 16'hFFFF, 15, 16'hFFFE, 14);
        check_all("R8");
        cyc(0, 0, 0, 0, 0, 0, 0);
        check_all("R7");
    endtask

    task automatic t_idle();
        cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 900, 7, 800, 8);
        cyc(0, 0, 1, 9999, 1, 9998, 2);
        check_all("R9");
        cyc(0, 0, 0, 0, 0, 0, 0);
        check_all("R9");
    endtask

    task automatic t_start_override();
        cyc(1, 1, 1, 1234, 3, 4321, 4);
        check_all("R2");
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        model_clear();
        @(negedge clk_i);
        @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_basic();
        t_ties();
        t_burst(20, 65535);
        t_after_done();
        t_burst(30, 7);
        t_burst(12, 300);
        t_idle();
        t_start_override();
        finish_run();
    end
endmodule